// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block resolves a translation miss. It receives a 20-bit virtual page number together with the base address of the root page table. It then reads one 32-bit entry from each of three table levels, one after another, over a plain valid/ready request port with a separate response strobe. Each entry that is valid gives the page frame of the next table. The leaf entry gives the physical page number, which the block presents on a fill port for loading into a translation buffer. If an entry at any level is invalid, the walk stops at once and the block reports a page fault for that virtual page.

Only one walk runs at a time. A new request is taken only while the machine is idle, and `busy` stays high for the whole walk. The machine moves through these states in order. ST_IDLE goes to ST_L1_REQ when a request arrives. Each ST_Ln_REQ goes to its ST_Ln_WAIT when the memory port accepts the read. ST_L1_WAIT and ST_L2_WAIT go on to the next level's request state when the entry is valid. ST_L3_WAIT goes to ST_DONE when its entry is valid. Any wait state goes to ST_FAULT when its entry is invalid. ST_DONE and ST_FAULT each last one cycle and then return to ST_IDLE.

Top module: `pt_walker`

## Requirements
- R1: After reset and while idle, `busy`, `mem_req_valid`, `fill_valid` and `fault_valid` are all low.
- R2: A request is accepted only when `req_valid` is high in the idle state. `busy` is high from the next cycle until the machine is idle again. A `req_valid` that arrives while busy is ignored: it starts no walk and does not change the page being translated.
- R3: The first read address is `req_ptbr + 4*vpn[19:13]`.
- R4: The second read address is `(E1[17:0] << 12) + 4*vpn[12:6]`, and the third is `(E2[17:0] << 12) + 4*vpn[5:0]`. Here En is the entry returned at level n, and entry bits 30:18 are ignored.
- R5: `mem_req_valid` stays high, with `mem_req_addr` unchanged, until `mem_req_ready` is seen. Exactly one read is issued per level, and no new read is issued while a response is outstanding. Any number of stall cycles and any response delay are tolerated.
- R6: When the returned entry has bit 31 clear at any level, `fault_valid` pulses for one cycle with `fault_vpn` equal to the accepted page, and no further reads are issued.
- R7: When all three entries are valid, `fill_valid` pulses for one cycle with `fill_ppn` equal to bits 17:0 of the level-three entry and `fill_vpn` equal to the accepted page.
- R8: `fill_valid` and `fault_valid` are never high together, and the machine is idle in the cycle after either pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Start a walk (taken only when idle) |
| req_vpn | input | 20 | Virtual page number to translate |
| req_ptbr | input | 32 | Byte address of the root table |
| busy | output | 1 | A walk is in progress |
| mem_req_valid | output | 1 | Read request pending |
| mem_req_ready | input | 1 | Memory accepts the read this cycle |
| mem_req_addr | output | 32 | Byte address of the entry to read |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Returned table entry |
| fill_valid | output | 1 | Translation ready for the buffer |
| fill_vpn | output | 20 | Virtual page of the translation |
| fill_ppn | output | 18 | Physical page number |
| fault_valid | output | 1 | Page fault raised |
| fault_vpn | output | 20 | Virtual page that faulted |

## Verification
The hardest case to reach from the ports is a walk that is held in a request or wait state for many cycles while a second request is pending. That is the only point where the request hold rule and the ignore-while-busy rule both apply at once. The memory model in the bench can hold `mem_req_ready` low and delay each response by a programmable number of cycles, so a walk can be stretched on purpose. A conflicting request is then driven into the middle of that stretch. Separate table images put the invalid entry at level one, two or three in turn, so that each exit to ST_FAULT is taken with its own read count.

// File: rtl/pt_walk_pkg.sv
package pt_walk_pkg;

    // Walk sequence; order follows the chain of dependent reads.
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_L1_REQ,
        ST_L1_WAIT,
        ST_L2_REQ,
        ST_L2_WAIT,
        ST_L3_REQ,
        ST_L3_WAIT,
        ST_DONE,
        ST_FAULT
    } ptw_state_e;

    typedef enum logic [1:0] {
        PTW_LVL1,
        PTW_LVL2,
        PTW_LVL3
    } ptw_level_e;

endpackage

// File: rtl/ptw_index_sel.sv
module ptw_index_sel
    import pt_walk_pkg::*;
#(
    parameter int L1_W  = 7,
    parameter int L2_W  = 7,
    parameter int L3_W  = 6,
    parameter int IDX_W = 7
) (
    input  logic [L1_W+L2_W+L3_W-1:0] vpn,
    input  ptw_level_e                level,
    output logic [IDX_W-1:0]          idx
);

    // Level three index sits at the bottom of the page number.
    localparam int L3_LO = 0;
    localparam int L2_LO = L3_W;
    localparam int L1_LO = L3_W + L2_W;

    always_comb begin
        unique case (level)
            PTW_LVL1: idx = IDX_W'(vpn[L1_LO +: L1_W]);
            PTW_LVL2: idx = IDX_W'(vpn[L2_LO +: L2_W]);
            PTW_LVL3: idx = IDX_W'(vpn[L3_LO +: L3_W]);
            default:  idx = '0;
        endcase
    end

endmodule

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen #(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 7
) (
    input  logic [ADDR_W-1:0] table_base,
    input  logic [IDX_W-1:0]  idx,
    output logic [ADDR_W-1:0] entry_addr
);

    // Entries are four bytes wide.
    localparam int ENTRY_SHIFT = 2;

    always_comb begin
        entry_addr = table_base + ADDR_W'({idx, {ENTRY_SHIFT{1'b0}}});
    end

endmodule

// File: rtl/ptw_pte_decode.sv
module ptw_pte_decode #(
    parameter int ENTRY_W    = 32,
    parameter int PPN_W      = 18,
    parameter int ADDR_W     = 32,
    parameter int PAGE_SHIFT = 12,
    parameter int VALID_BIT  = 31
) (
    input  logic [ENTRY_W-1:0] entry,
    output logic               pte_valid,
    output logic [PPN_W-1:0]   pte_ppn,
    output logic [ADDR_W-1:0]  next_base
);

    localparam int PAD_W = ADDR_W - PPN_W - PAGE_SHIFT;

    logic unused_entry_bits;

    always_comb begin
        pte_valid = entry[VALID_BIT];
        pte_ppn   = entry[PPN_W-1:0];
        next_base = {{PAD_W{1'b0}}, pte_ppn, {PAGE_SHIFT{1'b0}}};
    end

    assign unused_entry_bits = ^entry;

endmodule

// File: rtl/pt_walker.sv
module pt_walker
    import pt_walk_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int ENTRY_W    = 32,
    parameter int PPN_W      = 18,
    parameter int L1_W       = 7,
    parameter int L2_W       = 7,
    parameter int L3_W       = 6,
    parameter int PAGE_SHIFT = 12,
    parameter int VALID_BIT  = 31,
    parameter int VPN_W      = L1_W + L2_W + L3_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [VPN_W-1:0]  req_vpn,
    input  logic [ADDR_W-1:0] req_ptbr,
    output logic              busy,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [ADDR_W-1:0] mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [ENTRY_W-1:0] mem_rsp_data,
    output logic              fill_valid,
    output logic [VPN_W-1:0]  fill_vpn,
    output logic [PPN_W-1:0]  fill_ppn,
    output logic              fault_valid,
    output logic [VPN_W-1:0]  fault_vpn
);

    localparam int IDX12_W = (L1_W > L2_W) ? L1_W : L2_W;
    localparam int IDX_W   = (IDX12_W > L3_W) ? IDX12_W : L3_W;

    ptw_state_e        state_q, state_d;
    ptw_level_e        level;
    logic [VPN_W-1:0]  vpn_q;
    logic [ADDR_W-1:0] base_q;
    logic [PPN_W-1:0]  ppn_q;
    logic [IDX_W-1:0]  idx;
    logic [ADDR_W-1:0] entry_addr;
    logic              pte_valid;
    logic [PPN_W-1:0]  pte_ppn;
    logic [ADDR_W-1:0] next_base;
    logic              waiting;
    logic              rsp_take;
    logic              accept;

    ptw_index_sel #(
        .L1_W (L1_W),
        .L2_W (L2_W),
        .L3_W (L3_W),
        .IDX_W(IDX_W)
    ) i_index_sel (
        .vpn  (vpn_q),
        .level(level),
        .idx  (idx)
    );

    ptw_addr_gen #(
        .ADDR_W(ADDR_W),
        .IDX_W (IDX_W)
    ) i_addr_gen (
        .table_base(base_q),
        .idx       (idx),
        .entry_addr(entry_addr)
    );

    ptw_pte_decode #(
        .ENTRY_W   (ENTRY_W),
        .PPN_W     (PPN_W),
        .ADDR_W    (ADDR_W),
        .PAGE_SHIFT(PAGE_SHIFT),
        .VALID_BIT (VALID_BIT)
    ) i_pte_decode (
        .entry    (mem_rsp_data),
        .pte_valid(pte_valid),
        .pte_ppn  (pte_ppn),
        .next_base(next_base)
    );

    // Level being walked and whether a response is awaited.
    always_comb begin
        level   = PTW_LVL1;
        waiting = 1'b0;
        unique case (state_q)
            ST_L1_REQ:  level = PTW_LVL1;
            ST_L1_WAIT: begin level = PTW_LVL1; waiting = 1'b1; end
            ST_L2_REQ:  level = PTW_LVL2;
            ST_L2_WAIT: begin level = PTW_LVL2; waiting = 1'b1; end
            ST_L3_REQ:  level = PTW_LVL3;
            ST_L3_WAIT: begin level = PTW_LVL3; waiting = 1'b1; end
            default:    level = PTW_LVL1;
        endcase
    end

    assign rsp_take = waiting && mem_rsp_valid;
    assign accept   = (state_q == ST_IDLE) && req_valid;

    // Next-state selection.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (req_valid)     state_d = ST_L1_REQ;
            ST_L1_REQ:  if (mem_req_ready) state_d = ST_L1_WAIT;
            ST_L1_WAIT: if (mem_rsp_valid) state_d = pte_valid ? ST_L2_REQ : ST_FAULT;
            ST_L2_REQ:  if (mem_req_ready) state_d = ST_L2_WAIT;
            ST_L2_WAIT: if (mem_rsp_valid) state_d = pte_valid ? ST_L3_REQ : ST_FAULT;
            ST_L3_REQ:  if (mem_req_ready) state_d = ST_L3_WAIT;
            ST_L3_WAIT: if (mem_rsp_valid) state_d = pte_valid ? ST_DONE : ST_FAULT;
            ST_DONE:    state_d = ST_IDLE;
            ST_FAULT:   state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Walk context: page being translated, current table base, last page number.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vpn_q  <= '0;
            base_q <= '0;
            ppn_q  <= '0;
        end else begin
            if (accept) begin
                vpn_q  <= req_vpn;
                base_q <= req_ptbr;
            end
            if (rsp_take && pte_valid) begin
                base_q <= next_base;
                ppn_q  <= pte_ppn;
            end
        end
    end

    // Outputs decoded from the registered state.
    always_comb begin
        busy          = 1'b1;
        mem_req_valid = 1'b0;
        fill_valid    = 1'b0;
        fault_valid   = 1'b0;
        unique case (state_q)
            ST_IDLE:   busy = 1'b0;
            ST_L1_REQ,
            ST_L2_REQ,
            ST_L3_REQ: mem_req_valid = 1'b1;
            ST_DONE:   fill_valid = 1'b1;
            ST_FAULT:  fault_valid = 1'b1;
            default:   busy = 1'b1;
        endcase
        mem_req_addr = entry_addr;
        fill_vpn     = vpn_q;
        fill_ppn     = ppn_q;
        fault_vpn    = vpn_q;
    end

endmodule

// File: rtl/pt_walker_checker.sv
module pt_walker_checker #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              busy,
    input logic              mem_req_valid,
    input logic              mem_req_ready,
    input logic [ADDR_W-1:0] mem_req_addr,
    input logic              fill_valid,
    input logic              fault_valid
);

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mem_req_valid && !fill_valid && !fault_valid));

    assert_busy_after_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy) |=> busy);

    assert_req_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

    assert_fault_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        fault_valid |=> (!fault_valid && !busy));

    assert_fill_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        fill_valid |=> (!fill_valid && !busy));

    assert_one_result_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(fill_valid && fault_valid));

endmodule

bind pt_walker pt_walker_checker #(.ADDR_W(ADDR_W)) i_pt_walker_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .busy         (busy),
    .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_req_ready),
    .mem_req_addr (mem_req_addr),
    .fill_valid   (fill_valid),
    .fault_valid  (fault_valid)
);

// File: tb/test_pt_walker.sv
module test_pt_walker;

    localparam int CLK_PERIOD = 10;
    localparam int NV = 6;

    // Vector: {ptbr[32], vpn[20], l2 frame[18], l3 frame[18], leaf[18], bad level[2]}
    localparam logic [107:0] VEC [NV] = '{
        {32'h0001_0000, 20'hABCDE, 18'h00100, 18'h00200, 18'h3FFFF, 2'd0},
        {32'h0002_0000, 20'h00000, 18'h00101, 18'h00201, 18'h00001, 2'd0},
        {32'h0003_0004, 20'hFFFFF, 18'h00102, 18'h00202, 18'h12345, 2'd0},
        {32'h0004_0000, 20'h12345, 18'h00103, 18'h00203, 18'h0ABCD, 2'd1},
        {32'h0005_0000, 20'h6789A, 18'h00104, 18'h00204, 18'h05555, 2'd2},
        {32'h0006_0000, 20'hBCDEF, 18'h00105, 18'h00205, 18'h2AAAA, 2'd3}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [19:0] req_vpn = '0;
    logic [31:0] req_ptbr = '0;
    logic        busy;
    logic        mem_req_valid;
    logic        mem_req_ready;
    logic [31:0] mem_req_addr;
    logic        mem_rsp_valid;
    logic [31:0] mem_rsp_data;
    logic        fill_valid;
    logic [19:0] fill_vpn;
    logic [17:0] fill_ppn;
    logic        fault_valid;
    logic [19:0] fault_vpn;

    int checks = 0;
    int errors = 0;

    logic [31:0] mem [logic [31:0]];
    int          req_stall = 0;
    int          rsp_lat = 0;
    int          hold_cnt = 0;
    int          lat_cnt = 0;
    bit          pend = 0;
    bit          holding = 0;
    bit          stall_bad = 0;
    bit          overlap_bad = 0;
    logic [31:0] pend_addr = '0;
    logic [31:0] hold_addr = '0;
    logic [31:0] rd_log [8];
    int          rd_cnt = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pt_walker i_pt_walker (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .req_vpn      (req_vpn),
        .req_ptbr     (req_ptbr),
        .busy         (busy),
        .mem_req_valid(mem_req_valid),
        .mem_req_ready(mem_req_ready),
        .mem_req_addr (mem_req_addr),
        .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data (mem_rsp_data),
        .fill_valid   (fill_valid),
        .fill_vpn     (fill_vpn),
        .fill_ppn     (fill_ppn),
        .fault_valid  (fault_valid),
        .fault_vpn    (fault_vpn)
    );

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] rd(input logic [31:0] a);
        return mem.exists(a) ? mem[a] : 32'h0;
    endfunction

    // Memory model: programmable ready stall and response delay.
    initial begin
        mem_req_ready = 1'b0;
        mem_rsp_valid = 1'b0;
        mem_rsp_data  = '0;
        forever begin
            @(negedge clk);
            mem_rsp_valid = 1'b0;
            if (pend) begin
                if (mem_req_valid) overlap_bad = 1;
                mem_req_ready = 1'b0;
                if (lat_cnt == 0) begin
                    mem_rsp_valid = 1'b1;
                    mem_rsp_data  = rd(pend_addr);
                    pend = 0;
                end else begin
                    lat_cnt--;
                end
            end else if (mem_req_valid) begin
                if (!holding) begin
                    holding = 1;
                    hold_addr = mem_req_addr;
                end else if (mem_req_addr != hold_addr) begin
                    stall_bad = 1;
                end
                if (hold_cnt > 0) begin
                    mem_req_ready = 1'b0;
                    hold_cnt--;
                end else begin
                    mem_req_ready = 1'b1;
                    pend = 1;
                    pend_addr = mem_req_addr;
                    lat_cnt = rsp_lat;
                    holding = 0;
                    if (rd_cnt < 8) rd_log[rd_cnt] = mem_req_addr;
                    rd_cnt++;
                    hold_cnt = req_stall;
                end
            end else begin
                mem_req_ready = 1'b0;
            end
        end
    end

    task automatic start_walk(input logic [31:0] base, input logic [19:0] vpn);
        rd_cnt = 0;
        hold_cnt = req_stall;
        @(negedge clk);
        req_valid = 1'b1;
        req_vpn   = vpn;
        req_ptbr  = base;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R2", "busy after accept", busy, 1);
    endtask

    task automatic wait_done(output bit got_fill, output bit got_fault,
                             output logic [19:0] o_vpn, output logic [17:0] o_ppn);
        int n = 0;
        while (!fill_valid && !fault_valid && n < 400) begin
            @(negedge clk);
            n++;
        end
        got_fill  = fill_valid;
        got_fault = fault_valid;
        o_vpn     = fill_valid ? fill_vpn : fault_vpn;
        o_ppn     = fill_ppn;
        @(negedge clk);
        chk("R8", "idle after result", busy, 0);
        chk("R8", "result is one cycle", fill_valid | fault_valid, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        bit          f_fill, f_fault;
        logic [19:0] o_vpn;
        logic [17:0] o_ppn;

        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1", "busy in reset", busy, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "busy idle", busy, 0);
        chk("R1", "no request idle", mem_req_valid, 0);
        chk("R1", "no fill idle", fill_valid, 0);
        chk("R1", "no fault idle", fault_valid, 0);

        // Table-driven walks.
        for (int i = 0; i < NV; i++) begin
            logic [31:0] base, a1, a2, a3;
            logic [19:0] vpn;
            logic [17:0] l2f, l3f, leaf;
            logic [1:0]  bad;
            int          nrd;
            {base, vpn, l2f, l3f, leaf, bad} = VEC[i];
            a1 = base + 32'({vpn[19:13], 2'b00});
            a2 = 32'({l2f, 12'h000}) + 32'({vpn[12:6], 2'b00});
            a3 = 32'({l3f, 12'h000}) + 32'({vpn[5:0], 2'b00});
            mem[a1] = {bad != 2'd1, 13'h155A, l2f};
            mem[a2] = {bad != 2'd2, 13'h0AA5, l3f};
            mem[a3] = {bad != 2'd3, 13'h1FFF, leaf};
            nrd = (bad == 2'd0) ? 3 : int'(bad);
            req_stall = i % 3;
            rsp_lat   = (i * 2) % 5;
            start_walk(base, vpn);
            wait_done(f_fill, f_fault, o_vpn, o_ppn);
            chk("R5", "read count", rd_cnt, nrd);
            chk("R3", "level one address", rd_log[0], a1);
            if (nrd > 1) chk("R4", "level two address", rd_log[1], a2);
            if (nrd > 2) chk("R4", "level three address", rd_log[2], a3);
            if (bad == 2'd0) begin
                chk("R7", "fill raised", f_fill, 1);
                chk("R7", "fill ppn", o_ppn, leaf);
                chk("R7", "fill vpn", o_vpn, vpn);
            end else begin
                chk("R6", "fault raised", f_fault, 1);
                chk("R6", "no fill on fault", f_fill, 0);
                chk("R6", "fault vpn", o_vpn, vpn);
            end
        end

        // R2: request during a walk is ignored (long stalls keep the walk busy).
        begin
            logic [31:0] base;
            logic [19:0] vpn;
            logic [17:0] l2f, l3f, leaf;
            logic [1:0]  bad;
            {base, vpn, l2f, l3f, leaf, bad} = VEC[0];
            req_stall = 4;
            rsp_lat   = 4;
            start_walk(base, vpn);
            @(negedge clk);
            req_valid = 1'b1;
            req_vpn   = 20'h55555;
            req_ptbr  = 32'h0007_0000;
            repeat (3) @(negedge clk);
            req_valid = 1'b0;
            wait_done(f_fill, f_fault, o_vpn, o_ppn);
            chk("R2", "walk unchanged by busy request vpn", o_vpn, vpn);
            chk("R2", "walk unchanged by busy request ppn", o_ppn, leaf);
            repeat (3) @(negedge clk);
            chk("R2", "no second walk reads", rd_cnt, 3);
            chk("R2", "still idle", busy, 0);
        end

        // R5: held requests kept their address, and reads never overlapped.
        chk("R5", "address stable under stall", stall_bad, 0);
        chk("R5", "no read while response pending", overlap_bad, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule